// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port

This block is the digital serial side of a two-channel voice codec. It runs entirely on the bit clock. A frame begins when the frame-sync input goes from low to high, as seen at a rising clock edge. Two 8-bit slots then follow back to back. Each bit of the receive line is taken in on a falling clock edge. Each bit of the transmit line is launched on a rising clock edge. Outside its 16 active bit periods the transmit line floats.

The received pair of bytes is offered as two parallel words with a one-cycle valid strobe. The transmit pair is taken from two parallel inputs, which are captured when the frame starts. A timer watches for frame sync going missing. If sync stays low too long while the clock runs, the block raises a power-down flag. The limit is 1024 clocks at the slow bit rate and 2048 clocks at the fast one. The next rising sync edge clears the flag.

Top module: `pcm_duo_port`

## Requirements
- R1: A frame-sync edge is a rising clock edge at which `fsync` is 1 after being 0 at the previous rising edge. The 16 bit periods that follow the edge carry channel 0 first and then channel 1, each byte most significant bit first. Bit 0 occupies the clock period that starts at the edge itself.
- R2: Each receive bit is the value of `rx_sd` at the falling clock edge in the middle of its bit period. A change of `rx_sd` between that falling edge and the next rising edge has no effect.
- R3: `tx_sd` changes only on rising clock edges. `tx_oe` is 1 during exactly the 16 active bit periods and 0 at all other times. When `tx_oe` is 0, `tx_sd` is high-impedance.
- R4: `tx_ch0` and `tx_ch1` are captured at the frame-sync edge. Changes to them later in the frame do not alter the bits sent.
- R5: Holding `fsync` high for more than one clock does not restart the frame. Only a 0-to-1 transition does.
- R6: After the 16th bit, `rx_valid` is 1 for exactly one clock period, the one that follows the last bit period. In that period, `rx_ch0` holds the first byte received and `rx_ch1` holds the second.
- R7: A new frame-sync edge before the 16th bit ends the current frame with no `rx_valid` pulse. Transfer then restarts at channel 0, bit 0.
- R8: `pdn` becomes 1 at the rising edge that completes N consecutive rising edges with `fsync` low. N is 1024 when `rate_sel` is 0 and 2048 when it is 1. `pdn` then stays 1 while `fsync` stays low.
- R9: A frame-sync edge clears `pdn` at that same clock edge.
- R10: While `rst_n` is low, and right after reset, `tx_oe`, `rx_valid` and `pdn` are 0 and both receive words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 0 selects the 1024-clock sync-loss limit, 1 selects 2048 |
| fsync | input | 1 | Frame sync, synchronous to `clk`; treat as low when undriven |
| rx_sd | input | 1 | Serial receive data |
| tx_ch0 | input | 8 | Transmit byte for channel 0 |
| tx_ch1 | input | 8 | Transmit byte for channel 1 |
| tx_sd | output | 1 | Serial transmit data, high-impedance when idle |
| tx_oe | output | 1 | High while `tx_sd` is driven |
| rx_ch0 | output | 8 | Last received channel 0 byte |
| rx_ch1 | output | 8 | Last received channel 1 byte |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |
| pdn | output | 1 | Power-down indication after sync loss |

## Verification
The bench targets these corner cases:

- **Falling-edge sampling.** The bench flips the receive line right after each falling edge. A port that samples on the rising edge would receive the inverted bytes.
- **Capture of the transmit words.** The bench scrambles `tx_ch0` and `tx_ch1` right after every sync edge. A design that failed to capture them at the edge would send the scrambled bytes.
- **Restart and abandoned frames.** Frames are restarted mid-way. A wrong design would either emit a stale valid pulse or carry on at the old bit position.
- **Long sync pulses.** Some frames hold sync high for several clocks. A level-triggered port would keep restarting at bit 0.
- **Sync-loss limit.** The power-down timer is checked one clock before and exactly at each limit, at both rates. An off-by-one or a wrong rate decode shows up as a flag raised a clock early or late.

// File: rtl/pcm_duo_pkg.sv
package pcm_duo_pkg;

    // number of voice channels carried per frame
    localparam int unsigned NUM_CH = 2;

    // sync-loss limit selector
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

endpackage

// File: rtl/pcm_fs_monitor.sv
module pcm_fs_monitor #(
    parameter int unsigned LOST_LO = 1024,
    parameter int unsigned LOST_HI = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic rate_sel,
    output logic fs_edge_o,
    output logic pdn_o
);
    import pcm_duo_pkg::*;

    localparam int unsigned MAX_LIM = (LOST_HI > LOST_LO) ? LOST_HI : LOST_LO;
    localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic             fs_prev;
        logic [CNT_W-1:0] lowcnt;
        logic             pdn;
    } mon_t;

    mon_t             cur_q, nxt_d;
    logic [CNT_W-1:0] limit;
    logic             edge_seen;

    always_comb begin
        limit     = (rate_e'(rate_sel) == RATE_FAST) ? CNT_W'(LOST_HI) : CNT_W'(LOST_LO);
        edge_seen = fsync && !cur_q.fs_prev;
        nxt_d     = cur_q;
        nxt_d.fs_prev = fsync;

        // count consecutive low samples, saturating at the active limit
        if (fsync) begin
            nxt_d.lowcnt = '0;
        end else if (cur_q.lowcnt < limit) begin
            nxt_d.lowcnt = cur_q.lowcnt + 1'b1;
        end

        // a sync edge clears power-down; reaching the limit sets it
        if (edge_seen) begin
            nxt_d.pdn = 1'b0;
        end else if (!fsync && (cur_q.lowcnt == limit - 1'b1)) begin
            nxt_d.pdn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fs_edge_o = edge_seen;
    assign pdn_o     = cur_q.pdn;

    // R9
    pdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !cur_q.fs_prev) |=> !pdn_o);

    // R8
    pdn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdn_o) |-> !$past(fsync));

    // R8
    pdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_o && !fsync) |=> pdn_o);

endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o,
    output logic last_o
);
    localparam int unsigned IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start_i) begin
            // any new edge, even mid-frame, restarts at the first bit
            nxt_d.active = 1'b1;
            nxt_d.idx    = '0;
        end else if (cur_q.active) begin
            if (cur_q.idx == LAST_IDX) begin
                nxt_d.active = 1'b0;
                nxt_d.idx    = '0;
            end else begin
                nxt_d.idx = cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active_o = cur_q.active;
    assign last_o   = cur_q.active && (cur_q.idx == LAST_IDX);

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [FRAME_BITS-1:0] word_i,
    input  logic                  active_i,
    output logic                  bit_o
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] sr;
    } tx_t;

    tx_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.sr = word_i;
        end else if (active_i) begin
            nxt_d.sr = {cur_q.sr[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bit_o = cur_q.sr[FRAME_BITS-1];

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_sd,
    input  logic                  active_i,
    input  logic                  last_i,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  valid_o
);
    typedef struct packed {
        logic [FRAME_BITS-2:0] sr;
        logic [FRAME_BITS-1:0] word;
        logic                  valid;
    } rx_t;

    rx_t  cur_q, nxt_d;
    logic smp_q;

    // mid-period sample taken on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else begin
            smp_q <= rx_sd;
        end
    end

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        if (active_i) begin
            nxt_d.sr = {cur_q.sr[FRAME_BITS-3:0], smp_q};
            if (last_i) begin
                nxt_d.word  = {cur_q.sr, smp_q};
                nxt_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign word_o  = cur_q.word;
    assign valid_o = cur_q.valid;

endmodule

// File: rtl/pcm_duo_port.sv
module pcm_duo_port #(
    parameter int unsigned SLOT_W  = 8,
    parameter int unsigned LOST_LO = 1024,
    parameter int unsigned LOST_HI = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel,
    input  logic              fsync,
    input  logic              rx_sd,
    input  logic [SLOT_W-1:0] tx_ch0,
    input  logic [SLOT_W-1:0] tx_ch1,
    output tri                tx_sd,
    output logic              tx_oe,
    output logic [SLOT_W-1:0] rx_ch0,
    output logic [SLOT_W-1:0] rx_ch1,
    output logic              rx_valid,
    output logic              pdn
);
    import pcm_duo_pkg::*;

    localparam int unsigned FRAME_BITS = NUM_CH * SLOT_W;

    logic                  fs_edge;
    logic                  active;
    logic                  last_bit;
    logic                  tx_bit;
    logic [FRAME_BITS-1:0] tx_frame;
    logic [FRAME_BITS-1:0] rx_frame;

    // channel 0 occupies the upper, earlier-shifted slot
    assign tx_frame = {tx_ch0, tx_ch1};

    pcm_fs_monitor #(.LOST_LO(LOST_LO), .LOST_HI(LOST_HI)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .rate_sel  (rate_sel),
        .fs_edge_o (fs_edge),
        .pdn_o     (pdn)
    );

    pcm_slot_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (fs_edge),
        .active_o (active),
        .last_o   (last_bit)
    );

    pcm_tx_shift #(.FRAME_BITS(FRAME_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (fs_edge),
        .word_i   (tx_frame),
        .active_i (active),
        .bit_o    (tx_bit)
    );

    pcm_rx_shift #(.FRAME_BITS(FRAME_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_sd    (rx_sd),
        .active_i (active),
        .last_i   (last_bit && !fs_edge),
        .word_o   (rx_frame),
        .valid_o  (rx_valid)
    );

    assign tx_oe  = active;
    assign tx_sd  = active ? tx_bit : 1'bz;
    assign rx_ch0 = rx_frame[FRAME_BITS-1 -: SLOT_W];
    assign rx_ch1 = rx_frame[SLOT_W-1:0];

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> rx_valid);

    // R7
    edge_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_edge |=> (tx_oe && !rx_valid));

endmodule

// File: tb/pcm_duo_port_bench.sv
`timescale 1ns/100ps
module pcm_duo_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_sel = 1'b0;
    logic       fsync = 1'b0;
    logic       rx_sd = 1'b0;
    logic [7:0] tx_ch0 = 8'h00;
    logic [7:0] tx_ch1 = 8'h00;
    wire        tx_sd;
    logic       tx_oe;
    logic [7:0] rx_ch0;
    logic [7:0] rx_ch1;
    logic       rx_valid;
    logic       pdn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcm_duo_port u_pcm_duo_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .fsync    (fsync),
        .rx_sd    (rx_sd),
        .tx_ch0   (tx_ch0),
        .tx_ch1   (tx_ch1),
        .tx_sd    (tx_sd),
        .tx_oe    (tx_oe),
        .rx_ch0   (rx_ch0),
        .rx_ch1   (rx_ch1),
        .rx_valid (rx_valid),
        .pdn      (pdn)
    );

    function automatic logic frame_bit(input logic [7:0] b0, input logic [7:0] b1, input int j);
        return (j < 8) ? b0[7-j] : b1[15-j];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one frame; returns 3 ns after the rising edge that ends its check window.
    // abort_at >= 0 raises a new sync edge during that bit; nt0/nt1 are then the next words.
    task automatic run_frame(input logic [7:0] t0, input logic [7:0] t1,
                             input logic [7:0] r0, input logic [7:0] r1,
                             input int hold, input int abort_at, input bit pre,
                             input logic [7:0] nt0, input logic [7:0] nt1);
        if (!pre) begin
            @(posedge clk); #1;
            fsync  = 1'b1;
            tx_ch0 = t0;
            tx_ch1 = t1;
        end
        @(posedge clk);
        for (int j = 0; j < 16; j++) begin
            #1;
            if (j == hold - 1) fsync = 1'b0;
            if (j == 0) begin
                // R4: scramble the words after capture
                tx_ch0 = 8'($urandom);
                tx_ch1 = 8'($urandom);
            end
            rx_sd = frame_bit(r0, r1, j);
            if (j == abort_at) begin
                fsync  = 1'b1;
                tx_ch0 = nt0;
                tx_ch1 = nt1;
            end
            #2;
            chk("R3", "tx_oe in slot", {31'b0, tx_oe}, 32'd1);
            chk("R1 R4 R5", "tx bit", {31'b0, tx_sd}, {31'b0, frame_bit(t0, t1, j)});
            chk("R7", "no valid inside frame", {31'b0, rx_valid}, 32'd0);
            // R2: corrupt the line after the falling edge
            rx_sd = ~rx_sd;
            if (j == abort_at) return;
            @(posedge clk);
        end
        #1;
        rx_sd = 1'($urandom);
        #2;
        chk("R3", "tx_oe after frame", {31'b0, tx_oe}, 32'd0);
        chk("R6", "valid after frame", {31'b0, rx_valid}, 32'd1);
        chk("R2 R6", "rx_ch0", {24'b0, rx_ch0}, {24'b0, r0});
        chk("R2 R6", "rx_ch1", {24'b0, rx_ch1}, {24'b0, r1});
        @(posedge clk); #3;
        chk("R6", "valid one cycle", {31'b0, rx_valid}, 32'd0);
        chk("R3", "line idle", {31'b0, tx_oe}, 32'd0);
    endtask

    task automatic pd_test(input logic rate, input int limit);
        @(posedge clk); #1;
        rate_sel = rate;
        fsync    = 1'b1;
        @(posedge clk); #1;
        fsync = 1'b0;
        #2;
        chk("R9", "edge clears pdn", {31'b0, pdn}, 32'd0);
        repeat (limit - 1) @(posedge clk);
        #3;
        chk("R8", "pdn one before limit", {31'b0, pdn}, 32'd0);
        @(posedge clk); #3;
        chk("R8", "pdn at limit", {31'b0, pdn}, 32'd1);
        repeat (5) @(posedge clk);
        #3;
        chk("R8", "pdn holds", {31'b0, pdn}, 32'd1);
    endtask

    initial begin
        logic [7:0] a0, a1, b0, b1;
        void'($urandom(32'h5eed_2024));
        #7;
        chk("R10", "reset tx_oe", {31'b0, tx_oe}, 32'd0);
        chk("R10", "reset valid", {31'b0, rx_valid}, 32'd0);
        chk("R10", "reset pdn", {31'b0, pdn}, 32'd0);
        chk("R10", "reset rx words", {16'b0, rx_ch0, rx_ch1}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        #2;
        chk("R10", "post reset tx_oe", {31'b0, tx_oe}, 32'd0);

        // directed patterns
        run_frame(8'hA5, 8'h3C, 8'h81, 8'h7E, 1, -1, 1'b0, 8'h00, 8'h00);
        run_frame(8'hFF, 8'h00, 8'h00, 8'hFF, 1, -1, 1'b0, 8'h00, 8'h00);
        // R5: sync held high for several clocks
        run_frame(8'h12, 8'h34, 8'hC3, 8'h5A, 4, -1, 1'b0, 8'h00, 8'h00);
        // R7: abort during channel 0, then during channel 1
        run_frame(8'h96, 8'h69, 8'h11, 8'h22, 1, 5, 1'b0, 8'hE7, 8'h18);
        run_frame(8'hE7, 8'h18, 8'h4D, 8'hB2, 1, 12, 1'b1, 8'h0F, 8'hF0);
        run_frame(8'h0F, 8'hF0, 8'h99, 8'h66, 1, -1, 1'b1, 8'h00, 8'h00);

        // random frames
        for (int n = 0; n < 40; n++) begin
            a0 = 8'($urandom); a1 = 8'($urandom);
            b0 = 8'($urandom); b1 = 8'($urandom);
            repeat ($urandom_range(0, 6)) @(posedge clk);
            run_frame(a0, a1, b0, b1, int'($urandom_range(1, 3)), -1, 1'b0, 8'h00, 8'h00);
        end

        // sync-loss limits at both rates
        pd_test(1'b0, 1024);
        pd_test(1'b1, 2048);
        run_frame(8'h5C, 8'hC5, 8'h3A, 8'hA3, 1, -1, 1'b0, 8'h00, 8'h00);
        chk("R9", "pdn cleared by frame", {31'b0, pdn}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule